// File: doc/BRIEF.md
# Dual Frame Buffer Fetch Sequencer

This block sequences the start of each display refresh frame. When the display path is switched on it first confirms that every frame buffer boundary address it will use lies inside an allowed address window. After that, on each frame tick it picks the active buffer (buffer 0 or buffer 1) and reads a palette header from that buffer's base. Each 32-bit word it reads becomes two 16-bit palette writes. The depth field in the first header word sets how long the header is and where the pixel data begins.

Once the header is in, the sequencer works out how many bytes the frame needs and compares that with the space the buffer bounds allow. If the frame fits, it raises a DMA completion condition and an optional interrupt, then hands the pixel start address, bits per pixel, first line and line count to a downstream pixel unpacker. If the frame does not fit, it stops with a sync error until it is switched off. In ping-pong mode the active buffer alternates after each frame that is handed over.

Top module: `fb_fetch_seq`

## Requirements
- R1: After reset, `running`, `rd_req`, `pal_we`, `px_go`, `dma_irq` and `sync_err` are low and `dma_cond` is 000.
- R2: When `lcd_en` rises, buffer 0 top and bottom, and in ping-pong mode buffer 1 top and bottom as well, must each lie in the inclusive range [`win_lo`, `win_hi`]. Buffer 1 is not checked outside ping-pong mode. If any checked address is outside the range, `dma_cond[2]` is set, `dma_irq` pulses if `dma_ie[1]` is 1, and `running` stays low until `lcd_en` is dropped.
- R3: On a frame tick in header mode 0 or 3, the sequencer reads 32-bit words at base, base+4, base+8 and so on, each through a `rd_req`/`rd_ack` handshake. Each word produces two palette writes: bits 15:0 go to the even index 2k first, and bits 31:16 go to the odd index 2k+1 next.
- R4: The depth code is bits 14:12 of the first header word. Codes 3 to 7 give a 128-word header (palette entries 0 to 255) and a pixel data offset of 0x200. Codes 0 to 2 give an 8-word header and an offset of 0x20.
- R5: In header mode 2 a frame tick causes no reads, the offset is 0, and the depth code kept from the last header is used. In header mode 1 frame ticks are ignored: no reads and no frame.
- R6: Bits per pixel on `px_bpp`: code 1 gives 2, code 2 gives 4, code 3 gives 8, codes 4 to 7 give 16. Code 0 skips the frame silently, with no `px_go` and no sync error.
- R7: The frame need is offset + width × height × bpp / 8, rounded down. If the need is greater than bottom − top + 2 of the active buffer, `sync_err` is set and `running` drops. A need exactly equal to that value is accepted.
- R8: A frame that fits produces a one-cycle `px_go` with `px_start` = base + offset. It sets `dma_cond[cur_buf]`, and `dma_irq` pulses in the same cycle only if `dma_ie[0]` is 1.
- R9: In ping-pong mode `cur_buf` toggles after each frame handed over. In single mode it stays 0. Each enable starts again at buffer 0.
- R10: With `sp_en` and `sp_first` both high, `px_first` = `sp_line` and `px_lines` = `height_ln`. With `sp_en` high and `sp_first` low, `px_first` = 0 and `px_lines` = `sp_line`. With `sp_en` low, `px_first` = 0 and `px_lines` = `height_ln`.
- R11: `pal_loaded` pulses once, when the first header after an enable completes, and not for any later header.
- R12: Dropping `lcd_en` clears `sync_err` and makes `running` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcd_en | input | 1 | Display path enable (level) |
| pal_mode | input | 2 | Header mode: 0/3 load, 1 no frames, 2 no header |
| dual_en | input | 1 | Ping-pong buffer mode |
| frame_tick | input | 1 | Frame start strobe |
| width_px | input | 11 | Pixels per line |
| height_ln | input | 11 | Lines per frame |
| sp_en | input | 1 | Subpanel override enable |
| sp_first | input | 1 | Subpanel value is first line (1) or line count (0) |
| sp_line | input | 10 | Subpanel line value |
| buf_top0 | input | 32 | Buffer 0 start address |
| buf_bot0 | input | 32 | Buffer 0 end address |
| buf_top1 | input | 32 | Buffer 1 start address |
| buf_bot1 | input | 32 | Buffer 1 end address |
| win_lo | input | 32 | Lowest valid address |
| win_hi | input | 32 | Highest valid address |
| dma_ie | input | 2 | Interrupt enables: bit 0 frame done, bit 1 bad address |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 8 | Palette entry index |
| pal_data | output | 16 | Palette entry value |
| pal_loaded | output | 1 | First header after enable complete (pulse) |
| dma_cond | output | 3 | Sticky DMA conditions: frame on buffer 0, buffer 1, bad address |
| dma_irq | output | 1 | DMA interrupt pulse |
| sync_err | output | 1 | Frame does not fit its buffer |
| running | output | 1 | Sequencer active |
| cur_buf | output | 1 | Active buffer index |
| px_go | output | 1 | Frame handed to unpacker (pulse) |
| px_start | output | 32 | Pixel data start address |
| px_lines | output | 11 | Lines to display |
| px_first | output | 11 | First line displayed |
| px_bpp | output | 5 | Bits per pixel |

## Verification
The hardest state to reach from the ports is header mode 2 with a known depth. No header is read in that mode, so the depth comes only from an earlier header. The stimulus first runs a normal frame in mode 0 with a chosen depth code, then switches mode while still enabled, and checks that no read appears and that the old depth drives `px_bpp`. Ping-pong order also needs several frames in a row followed by a disable and re-enable. The buffer-fit boundary is reached by computing each bottom address from the expected need, so that the slack is exactly 0 or −1.

// File: rtl/fbseq_pkg.sv
// Shared types and helpers for the frame fetch sequencer.
// Assumes depth codes are 3 bits wide and bits per pixel fit in 5 bits.
package fbseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_WAIT,
        ST_FETCH,
        ST_EVAL,
        ST_HALT
    } seq_state_t;

    localparam logic [1:0] MODE_NOFRAME = 2'd1;
    localparam logic [1:0] MODE_NOHDR   = 2'd2;

    // Map a depth code to bits per pixel (0 means unsupported).
    function automatic logic [4:0] depth_to_bpp(input logic [2:0] code);
        case (code)
            3'd0:    depth_to_bpp = 5'd0;
            3'd1:    depth_to_bpp = 5'd2;
            3'd2:    depth_to_bpp = 5'd4;
            3'd3:    depth_to_bpp = 5'd8;
            default: depth_to_bpp = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/fbseq_win_chk.sv
// Address window checker: reports whether every address that is flagged as
// in use lies inside the inclusive range [lo, hi]. Purely combinational.
// Assumes lo <= hi; addresses that are not flagged are treated as valid.
module fbseq_win_chk #(
    parameter int AW = 32,
    parameter int N  = 4
) (
    input  logic [AW-1:0] addr [N],
    input  logic [N-1:0]  in_use,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          all_ok
);

    logic [N-1:0] ok_vec;

    // One range comparator per address.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign ok_vec[i] = !in_use[i] || ((addr[i] >= lo) && (addr[i] <= hi));
    end

    assign all_ok = &ok_vec;

endmodule

// File: rtl/fbseq_size_chk.sv
// Frame size checker: derives bits per pixel and data offset from the depth
// code, computes the frame need in bytes, and compares it with the buffer
// capacity (bottom - top + 2). Purely combinational.
// Assumes width and height are at most 2**LINE_W-1.
module fbseq_size_chk
    import fbseq_pkg::*;
#(
    parameter int AW              = 32,
    parameter int LINE_W          = 11,
    parameter int PAL_ENTRIES     = 256,
    parameter int SMALL_HDR_BYTES = 32
) (
    input  logic [2:0]        depth,
    input  logic              no_hdr,
    input  logic [LINE_W-1:0] width,
    input  logic [LINE_W-1:0] height,
    input  logic [AW-1:0]     top,
    input  logic [AW-1:0]     bot,
    output logic [4:0]        bpp,
    output logic [AW-1:0]     data_off,
    output logic              unsupported,
    output logic              fits
);

    localparam int PW      = 2 * LINE_W + 5;
    localparam int SUM_W   = AW + 3;
    localparam int BIG_OFF = PAL_ENTRIES * 2;

    logic [PW-1:0]           pix_bits;
    logic [SUM_W-1:0]        need;
    logic signed [SUM_W:0]   cap;

    // Decode the depth code into bpp and header offset.
    always_comb begin
        bpp         = depth_to_bpp(depth);
        unsupported = (depth == 3'd0);
        if (no_hdr)
            data_off = '0;
        else if (depth >= 3'd3)
            data_off = AW'(BIG_OFF);
        else
            data_off = AW'(SMALL_HDR_BYTES);
    end

    // Byte need versus signed capacity of the active buffer.
    always_comb begin
        pix_bits = PW'(width) * PW'(height) * PW'(bpp);
        need     = SUM_W'(data_off) + SUM_W'(pix_bits >> 3);
        cap      = $signed({1'b0, SUM_W'(bot)}) - $signed({1'b0, SUM_W'(top)})
                   + $signed((SUM_W + 1)'(2));
        fits     = $signed({1'b0, need}) <= cap;
    end

endmodule

// File: rtl/fbseq_hdr_fetch.sv
// Palette header fetch engine: on start, reads consecutive 32-bit words from
// the given base and writes each as two palette entries, low half then high
// half. The first word's bits 14:12 set the header length. abort stops the
// transfer at once. Assumes rd_ack is only asserted while rd_req is high.
module fbseq_hdr_fetch #(
    parameter int AW              = 32,
    parameter int PAL_ENTRIES     = 256,
    parameter int SMALL_HDR_BYTES = 32,
    localparam int IDX_W          = $clog2(PAL_ENTRIES),
    localparam int BIG_WORDS      = PAL_ENTRIES / 2,
    localparam int SMALL_WORDS    = SMALL_HDR_BYTES / 4,
    localparam int CNT_W          = $clog2(BIG_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [AW-1:0]    base,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_ack,
    input  logic [31:0]      rd_data,
    output logic             pal_we,
    output logic [IDX_W-1:0] pal_idx,
    output logic [15:0]      pal_data,
    output logic [2:0]       hdr_depth,
    output logic             done
);

    logic             busy;
    logic             drain;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] words;
    logic [15:0]      hi_q;
    logic [AW-1:0]    base_q;

    assign rd_req  = busy && !drain;
    assign rd_addr = base_q + AW'({cnt, 2'b00});

    // Word loop: request, split into two palette writes, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            drain     <= 1'b0;
            cnt       <= '0;
            words     <= CNT_W'(SMALL_WORDS);
            hi_q      <= '0;
            base_q    <= '0;
            pal_we    <= 1'b0;
            pal_idx   <= '0;
            pal_data  <= '0;
            hdr_depth <= 3'd0;
            done      <= 1'b0;
        end else begin
            pal_we <= 1'b0;
            done   <= 1'b0;
            if (abort) begin
                busy  <= 1'b0;
                drain <= 1'b0;
            end else if (start && !busy) begin
                busy   <= 1'b1;
                drain  <= 1'b0;
                cnt    <= '0;
                base_q <= base;
            end else if (busy && drain) begin
                pal_we   <= 1'b1;
                pal_idx  <= pal_idx + IDX_W'(1);
                pal_data <= hi_q;
                drain    <= 1'b0;
                cnt      <= cnt + CNT_W'(1);
                if (cnt + CNT_W'(1) == words) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (busy && rd_ack) begin
                pal_we   <= 1'b1;
                pal_idx  <= {cnt[CNT_W-2:0], 1'b0};
                pal_data <= rd_data[15:0];
                hi_q     <= rd_data[31:16];
                drain    <= 1'b1;
                if (cnt == '0) begin
                    hdr_depth <= rd_data[14:12];
                    words     <= (rd_data[14:12] >= 3'd3) ? CNT_W'(BIG_WORDS)
                                                          : CNT_W'(SMALL_WORDS);
                end
            end
        end
    end

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
        rd_req && !rd_ack |=> rd_req);

    // R3
    lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
        pal_we && !pal_idx[0] |=> pal_we && pal_idx[0]);

endmodule

// File: rtl/fb_fetch_seq.sv
// Dual frame buffer fetch sequencer top. Checks buffer addresses on enable,
// loads the palette header per frame, checks the frame size and hands the
// frame to the pixel unpacker, toggling buffers in ping-pong mode.
// Assumes frame_tick only matters while waiting for a frame.
module fb_fetch_seq
    import fbseq_pkg::*;
#(
    parameter int AW              = 32,
    parameter int LINE_W          = 11,
    parameter int SP_W            = 10,
    parameter int PAL_ENTRIES     = 256,
    parameter int SMALL_HDR_BYTES = 32,
    localparam int IDX_W          = $clog2(PAL_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcd_en,
    input  logic [1:0]        pal_mode,
    input  logic              dual_en,
    input  logic              frame_tick,
    input  logic [LINE_W-1:0] width_px,
    input  logic [LINE_W-1:0] height_ln,
    input  logic              sp_en,
    input  logic              sp_first,
    input  logic [SP_W-1:0]   sp_line,
    input  logic [AW-1:0]     buf_top0,
    input  logic [AW-1:0]     buf_bot0,
    input  logic [AW-1:0]     buf_top1,
    input  logic [AW-1:0]     buf_bot1,
    input  logic [AW-1:0]     win_lo,
    input  logic [AW-1:0]     win_hi,
    input  logic [1:0]        dma_ie,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    output logic              pal_we,
    output logic [IDX_W-1:0]  pal_idx,
    output logic [15:0]       pal_data,
    output logic              pal_loaded,
    output logic [2:0]        dma_cond,
    output logic              dma_irq,
    output logic              sync_err,
    output logic              running,
    output logic              cur_buf,
    output logic              px_go,
    output logic [AW-1:0]     px_start,
    output logic [LINE_W-1:0] px_lines,
    output logic [LINE_W-1:0] px_first,
    output logic [4:0]        px_bpp
);

    seq_state_t     st;
    logic           first_hdr;
    logic           no_hdr;
    logic           addr_ok;
    logic [AW-1:0]  chk_addr [4];
    logic           hdr_start;
    logic           hdr_done;
    logic [2:0]     hdr_depth;
    logic [AW-1:0]  act_top;
    logic [AW-1:0]  act_bot;
    logic [4:0]     bpp;
    logic [AW-1:0]  data_off;
    logic           unsupported;
    logic           fits;

    assign chk_addr[0] = buf_top0;
    assign chk_addr[1] = buf_bot0;
    assign chk_addr[2] = buf_top1;
    assign chk_addr[3] = buf_bot1;
    assign act_top     = cur_buf ? buf_top1 : buf_top0;
    assign act_bot     = cur_buf ? buf_bot1 : buf_bot0;
    assign running     = (st != ST_OFF) && (st != ST_HALT);
    assign hdr_start   = (st == ST_WAIT) && frame_tick &&
                         (pal_mode != MODE_NOFRAME) && (pal_mode != MODE_NOHDR);

    fbseq_win_chk #(.AW(AW), .N(4)) u_win (
        .addr   (chk_addr),
        .in_use ({dual_en, dual_en, 2'b11}),
        .lo     (win_lo),
        .hi     (win_hi),
        .all_ok (addr_ok)
    );

    fbseq_hdr_fetch #(
        .AW(AW), .PAL_ENTRIES(PAL_ENTRIES), .SMALL_HDR_BYTES(SMALL_HDR_BYTES)
    ) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (hdr_start),
        .abort     (!lcd_en),
        .base      (act_top),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .pal_we    (pal_we),
        .pal_idx   (pal_idx),
        .pal_data  (pal_data),
        .hdr_depth (hdr_depth),
        .done      (hdr_done)
    );

    fbseq_size_chk #(
        .AW(AW), .LINE_W(LINE_W), .PAL_ENTRIES(PAL_ENTRIES),
        .SMALL_HDR_BYTES(SMALL_HDR_BYTES)
    ) u_size (
        .depth       (hdr_depth),
        .no_hdr      (no_hdr),
        .width       (width_px),
        .height      (height_ln),
        .top         (act_top),
        .bot         (act_bot),
        .bpp         (bpp),
        .data_off    (data_off),
        .unsupported (unsupported),
        .fits        (fits)
    );

    // Frame sequencing, conditions and unpacker hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_OFF;
            cur_buf    <= 1'b0;
            first_hdr  <= 1'b0;
            no_hdr     <= 1'b0;
            sync_err   <= 1'b0;
            dma_cond   <= 3'b000;
            dma_irq    <= 1'b0;
            pal_loaded <= 1'b0;
            px_go      <= 1'b0;
            px_start   <= '0;
            px_lines   <= '0;
            px_first   <= '0;
            px_bpp     <= '0;
        end else begin
            dma_irq    <= 1'b0;
            pal_loaded <= 1'b0;
            px_go      <= 1'b0;
            if (!lcd_en) begin
                st       <= ST_OFF;
                sync_err <= 1'b0;
            end else begin
                case (st)
                    ST_OFF: st <= ST_ARM;
                    ST_ARM: begin
                        if (addr_ok) begin
                            st        <= ST_WAIT;
                            cur_buf   <= 1'b0;
                            first_hdr <= 1'b1;
                        end else begin
                            dma_cond[2] <= 1'b1;
                            dma_irq     <= dma_ie[1];
                            st          <= ST_HALT;
                        end
                    end
                    ST_WAIT: begin
                        if (frame_tick && pal_mode != MODE_NOFRAME) begin
                            no_hdr <= (pal_mode == MODE_NOHDR);
                            st     <= (pal_mode == MODE_NOHDR) ? ST_EVAL : ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        if (hdr_done) begin
                            pal_loaded <= first_hdr;
                            first_hdr  <= 1'b0;
                            st         <= ST_EVAL;
                        end
                    end
                    ST_EVAL: begin
                        if (unsupported) begin
                            st <= ST_WAIT;
                        end else if (!fits) begin
                            sync_err <= 1'b1;
                            st       <= ST_HALT;
                        end else begin
                            dma_cond[{1'b0, cur_buf}] <= 1'b1;
                            dma_irq  <= dma_ie[0];
                            px_go    <= 1'b1;
                            px_start <= act_top + data_off;
                            px_bpp   <= bpp;
                            px_first <= (sp_en && sp_first) ? LINE_W'(sp_line) : '0;
                            px_lines <= (sp_en && !sp_first) ? LINE_W'(sp_line) : height_ln;
                            if (dual_en)
                                cur_buf <= ~cur_buf;
                            st <= ST_WAIT;
                        end
                    end
                    default: st <= st;
                endcase
            end
        end
    end

    // R8
    go_while_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        px_go |-> running);

    // R7
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> !running);

    // R2
    bad_addr_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_cond[2]) |-> !running);

    // R8
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> (dma_cond != 3'b000));

    // R12
    off_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_en |=> !sync_err && !running);

endmodule

// File: tb/fb_fetch_seq_bench.sv
module fb_fetch_seq_bench;

    localparam logic [31:0] WIN_LO = 32'h0000_1000;
    localparam logic [31:0] WIN_HI = 32'h00FF_FFFF;
    localparam logic [31:0] TOP0   = 32'h0001_0000;
    localparam logic [31:0] TOP1   = 32'h0002_0000;
    localparam int NV = 9;
    localparam int V_DEP [NV] = '{1, 2, 3, 5, 4, 6, 0, 7, 2};
    localparam int V_W   [NV] = '{16, 32, 20, 8, 10, 10, 4, 1, 5};
    localparam int V_H   [NV] = '{4, 8, 10, 8, 6, 6, 4, 1, 3};
    localparam int V_SPE [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0};
    localparam int V_SPF [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
    localparam int V_SPL [NV] = '{0, 0, 0, 0, 3, 2, 0, 0, 0};
    localparam int V_SLK [NV] = '{0, 5, 0, -1, 7, 0, 10, 100, -1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lcd_en = 1'b0;
    logic [1:0]  pal_mode = 2'd0;
    logic        dual_en = 1'b0;
    logic        frame_tick = 1'b0;
    logic [10:0] width_px = 11'd1;
    logic [10:0] height_ln = 11'd1;
    logic        sp_en = 1'b0;
    logic        sp_first = 1'b0;
    logic [9:0]  sp_line = '0;
    logic [31:0] buf_top0 = TOP0;
    logic [31:0] buf_bot0 = TOP0 + 32'h1000;
    logic [31:0] buf_top1 = TOP1;
    logic [31:0] buf_bot1 = TOP1 + 32'h1000;
    logic [1:0]  dma_ie = 2'b01;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack;
    logic [31:0] rd_data;
    logic        pal_we;
    logic [7:0]  pal_idx;
    logic [15:0] pal_data;
    logic        pal_loaded;
    logic [2:0]  dma_cond;
    logic        dma_irq;
    logic        sync_err;
    logic        running;
    logic        cur_buf;
    logic        px_go;
    logic [31:0] px_start;
    logic [10:0] px_lines;
    logic [10:0] px_first;
    logic [4:0]  px_bpp;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int pal_n = 0, pal_bad = 0, rd_n = 0, ld_n = 0, irq_n = 0;
    logic [31:0] exp_base = TOP0;
    logic [31:0] hdr0 = '0;
    logic [31:0] hdr1 = '0;

    always #2 clk = ~clk;

    fb_fetch_seq u_fb_fetch_seq (
        .clk(clk), .rst_n(rst_n), .lcd_en(lcd_en), .pal_mode(pal_mode),
        .dual_en(dual_en), .frame_tick(frame_tick), .width_px(width_px),
        .height_ln(height_ln), .sp_en(sp_en), .sp_first(sp_first),
        .sp_line(sp_line), .buf_top0(buf_top0), .buf_bot0(buf_bot0),
        .buf_top1(buf_top1), .buf_bot1(buf_bot1), .win_lo(WIN_LO),
        .win_hi(WIN_HI), .dma_ie(dma_ie), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .pal_we(pal_we), .pal_idx(pal_idx),
        .pal_data(pal_data), .pal_loaded(pal_loaded), .dma_cond(dma_cond),
        .dma_irq(dma_irq), .sync_err(sync_err), .running(running),
        .cur_buf(cur_buf), .px_go(px_go), .px_start(px_start),
        .px_lines(px_lines), .px_first(px_first), .px_bpp(px_bpp)
    );

    function automatic logic [31:0] memword(input logic [31:0] a);
        if (a == buf_top0) return hdr0;
        if (a == buf_top1) return hdr1;
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    function automatic logic [31:0] mkhdr(input int d);
        return {16'hBEEF, 1'b0, 3'(d), 12'h3C5};
    endfunction

    function automatic int bpp_of(input int d);
        return (d == 0) ? 0 : (d == 1) ? 2 : (d == 2) ? 4 : (d == 3) ? 8 : 16;
    endfunction

    function automatic int off_of(input int d);
        return (d >= 3) ? 512 : 32;
    endfunction

    // Memory model: one-cycle registered acknowledge.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_ack  <= rd_req && !rd_ack;
            rd_data <= memword(rd_addr);
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (pal_we) begin
            logic [31:0] w;
            logic [15:0] e;
            pal_n++;
            w = memword(exp_base + {23'd0, pal_idx[7:1], 2'b00});
            e = pal_idx[0] ? w[31:16] : w[15:0];
            if (pal_data !== e) pal_bad++;
        end
        if (rd_ack) rd_n++;
        if (pal_loaded) ld_n++;
        if (dma_irq) irq_n++;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lcd_en = 1'b0; frame_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic enable_on();
        @(negedge clk);
        lcd_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Pulse frame_tick, then wait for a hand-off, an error or a timeout.
    task automatic tick_wait(output bit go, output bit err);
        go = 0; err = 0;
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (px_go) begin go = 1; break; end
            if (sync_err) begin err = 1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        bit go, err;
        int p0, r0, l0, q0, need, words;

        // R1: reset state
        do_reset();
        check("R1 running", running, 0);
        check("R1 rd_req", rd_req, 0);
        check("R1 pal_we", pal_we, 0);
        check("R1 px_go", px_go, 0);
        check("R1 dma_irq", dma_irq, 0);
        check("R1 sync_err", sync_err, 0);
        check("R1 dma_cond", dma_cond, 0);

        // Vector table: depth, geometry, subpanel and buffer slack.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            hdr0 = mkhdr(V_DEP[v]);
            exp_base = TOP0;
            width_px = 11'(V_W[v]);
            height_ln = 11'(V_H[v]);
            sp_en = V_SPE[v][0];
            sp_first = V_SPF[v][0];
            sp_line = 10'(V_SPL[v]);
            dual_en = 1'b0; pal_mode = 2'd0; dma_ie = 2'b01;
            need = off_of(V_DEP[v]) + (V_W[v] * V_H[v] * bpp_of(V_DEP[v])) / 8;
            buf_bot0 = TOP0 + 32'(need - 2 + V_SLK[v]);
            words = (V_DEP[v] >= 3) ? 128 : 8;
            enable_on();
            p0 = pal_n; l0 = ld_n; q0 = irq_n;
            tick_wait(go, err);
            repeat (3) @(negedge clk);
            check($sformatf("R7 go v%0d", v), go, (V_DEP[v] != 0) && (V_SLK[v] >= 0));
            check($sformatf("R7 err v%0d", v), err, (V_DEP[v] != 0) && (V_SLK[v] < 0));
            check($sformatf("R4 hdr writes v%0d", v), pal_n - p0, 2 * words);
            check($sformatf("R3 pal data v%0d", v), pal_bad, 0);
            check($sformatf("R11 loaded v%0d", v), ld_n - l0, 1);
            check($sformatf("R8 irq v%0d", v), irq_n - q0, go);
            check($sformatf("R8 cond v%0d", v), dma_cond, {2'b00, go});
            if (err) check($sformatf("R7 halted v%0d", v), running, 0);
            if (V_DEP[v] == 0) check($sformatf("R6 skip running v%0d", v), running, 1);
            if (go) begin
                check($sformatf("R4 start v%0d", v), px_start, TOP0 + 32'(off_of(V_DEP[v])));
                check($sformatf("R6 bpp v%0d", v), px_bpp, bpp_of(V_DEP[v]));
                check($sformatf("R10 first v%0d", v), px_first,
                      (V_SPE[v] != 0 && V_SPF[v] != 0) ? V_SPL[v] : 0);
                check($sformatf("R10 lines v%0d", v), px_lines,
                      (V_SPE[v] != 0 && V_SPF[v] == 0) ? V_SPL[v] : V_H[v]);
            end
        end

        // R12: disabling clears the sync error left by the last vector
        @(negedge clk); lcd_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 sync_err cleared", sync_err, 0);
        check("R12 running low", running, 0);

        // R9 / R11: ping-pong order and restart at buffer 0
        do_reset();
        hdr0 = mkhdr(3); hdr1 = mkhdr(3);
        width_px = 11'd8; height_ln = 11'd8; sp_en = 1'b0;
        buf_bot0 = TOP0 + 32'h1000; buf_bot1 = TOP1 + 32'h1000;
        dual_en = 1'b1; dma_ie = 2'b00;
        enable_on();
        l0 = ld_n; q0 = irq_n;
        exp_base = TOP0; tick_wait(go, err);
        check("R9 frame A start", px_start, TOP0 + 32'h200);
        @(negedge clk);
        check("R9 toggled to 1", cur_buf, 1);
        exp_base = TOP1; tick_wait(go, err);
        check("R9 frame B start", px_start, TOP1 + 32'h200);
        @(negedge clk);
        check("R8 both conds", dma_cond, 3'b011);
        check("R8 no irq when disabled", irq_n - q0, 0);
        check("R11 one loaded pulse", ld_n - l0, 1);
        check("R3 pal data dual", pal_bad, 0);
        exp_base = TOP0; tick_wait(go, err);
        check("R9 frame C start", px_start, TOP0 + 32'h200);
        exp_base = TOP1; tick_wait(go, err);
        @(negedge clk); lcd_en = 1'b0;
        repeat (2) @(negedge clk);
        enable_on();
        check("R9 restart index", cur_buf, 0);
        exp_base = TOP0; tick_wait(go, err);
        check("R9 restart start", px_start, TOP0 + 32'h200);

        // R5: mode 1 ignores frame ticks
        do_reset();
        dual_en = 1'b0; pal_mode = 2'd1; hdr0 = mkhdr(1);
        enable_on();
        r0 = rd_n;
        exp_base = TOP0; tick_wait(go, err);
        check("R5 mode1 no frame", go, 0);
        check("R5 mode1 no reads", rd_n - r0, 0);

        // R5: mode 2 reuses the last depth and reads nothing
        do_reset();
        pal_mode = 2'd0; hdr0 = mkhdr(1); dma_ie = 2'b01;
        enable_on();
        tick_wait(go, err);
        @(negedge clk); pal_mode = 2'd2;
        r0 = rd_n;
        tick_wait(go, err);
        check("R5 mode2 frame", go, 1);
        check("R5 mode2 start", px_start, TOP0);
        check("R5 mode2 bpp kept", px_bpp, 2);
        check("R5 mode2 no reads", rd_n - r0, 0);

        // R2: buffer 1 out of window, single mode ignores it
        do_reset();
        pal_mode = 2'd0; dual_en = 1'b0; dma_ie = 2'b10;
        buf_top0 = WIN_LO; buf_top1 = 32'h0000_0010;
        q0 = irq_n;
        enable_on();
        check("R2 single ignores buf1", running, 1);
        check("R2 single no cond", dma_cond[2], 0);
        do_reset();
        dual_en = 1'b1;
        enable_on();
        check("R2 dual bad halts", running, 0);
        check("R2 dual bad cond", dma_cond[2], 1);
        check("R2 dual bad irq", irq_n - q0, 1);
        do_reset();
        buf_top1 = TOP1; buf_bot1 = WIN_HI + 32'd1;
        enable_on();
        check("R2 bottom above window", dma_cond[2], 1);
        do_reset();
        buf_bot1 = WIN_HI;
        enable_on();
        check("R2 window edge accepted", running, 1);

        summary();
        $finish;
    end

endmodule